// File: doc/BRIEF.md
# Serial Control Register Slave

This block is a two-wire serial slave that holds the configuration of a mixed-signal front end in seven writable 8-bit registers, plus one read-only status register whose contents come from outside. Both serial lines are oversampled by the system clock. Each line passes through a two-flop synchroniser and a glitch filter before start, stop and clock edges are decoded. The block never stretches the serial clock.

A host writes a register in three bytes: the device address, a pointer byte, and the data byte. A host reads a register in one of two ways. It can set the pointer, issue a repeated start and read one byte. Or it can set the readback flag in the pointer byte, so that the slave returns the register right after the data write, in the same transaction. All writable register bits appear as parallel outputs. These are plain control levels with no handshake. An active-low reset pin clears the register file at once, and the reset does not depend on the clock.

Top module: `ctlreg_i2c_slave`

## Requirements
- R1: After reset, register 2 holds 0x33 and every other writable register holds 0x00. Register k appears on ctl_o[8k+7:8k] for k = 0 to 6.
- R2: The slave acknowledges only the 7-bit address 0011010, which is the byte 0x34 for a write and 0x35 for a read. It answers no other address, acknowledges nothing more in that transaction, and changes no register.
- R3: In a write transaction the slave acknowledges the address, the pointer byte and the data byte. The data reaches the selected register and shows on ctl_o once the data byte has been acknowledged.
- R4: In the pointer byte, bits 2:0 select the register and bit 3 is the readback flag. Bits 7:4 have no effect.
- R5: After a pointer byte with the readback flag at 0, a repeated start and the address 0x35 make the slave send the selected register, MSB first. The slave then releases SDA for the master's acknowledge bit.
- R6: When the readback flag is 1, the slave sends the selected register in the 8 clocks that follow the data byte's acknowledge. The value sent is the one after the write, and no new address phase is needed.
- R7: A read of register 7 returns status_i. A write to register 7, with or without readback, changes no output.
- R8: A low level on rst_n returns every register to its R1 value at once. Register 0 bit 5 is an ordinary stored bit, and setting it clears no other register.
- R9: A start seen at any point, even in the middle of a byte, restarts address reception. A stop returns the slave to idle.
- R10: A line level must hold for FILT_LEN system clocks before the slave acts on it, so a single-clock SCL pulse adds no bit. sda_oe changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (2.048 MHz), also the line oversampling clock |
| rst_n | input | 1 | Active-low reset of the register file and bus logic, asynchronous |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| status_i | input | 8 | Contents of read-only register 7 |
| ctl_o | output | 56 | Writable registers 0 to 6, register k in bits 8k+7:8k |

## Verification
The bench targets the readback form. There the write pulse and the load of the transmit shifter are a whole serial bit apart, so a design that loaded early would return the old value. It sends bytes to address 0x36, and a design that compared only part of the address would acknowledge them and alter registers. It also breaks off a pointer byte with a new start, and a design whose bit counter survived the start would shift the next address. A single-clock SCL pulse in the middle of a data byte would show up as a corrupted register in an unfiltered design. Writes to register 7 and pointer bytes with high bits set show whether the decode is too wide.

// File: rtl/ctlreg_pkg.sv
`timescale 1ns/1ps
package ctlreg_pkg;
  localparam int DW      = 8;
  localparam int AW      = 3;
  localparam int NREG    = 1 << AW;
  localparam int RO_IDX  = NREG - 1;
  localparam int NW      = NREG - 1;
  localparam int CFG_IDX = 2;
  localparam logic [DW-1:0] CFG_RST = 8'h33;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_PTR, ST_WDAT, ST_RDAT
  } eng_state_t;

  function automatic logic [NW*DW-1:0] rst_image();
    logic [NW*DW-1:0] v;
    v = '0;
    for (int k = 0; k < NW; k++)
      v[k*DW +: DW] = (k == CFG_IDX) ? CFG_RST : '0;
    return v;
  endfunction
endpackage

// File: rtl/i2c_line_filter.sv
`timescale 1ns/1ps
module i2c_line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b1;
      s2     <= 1'b1;
      line_o <= 1'b1;
      cnt    <= '0;
    end else begin
      s1 <= line_i;
      s2 <= s1;
      if (s2 == line_o) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        line_o <= s2;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_byte_engine.sv
`timescale 1ns/1ps
module i2c_byte_engine
  import ctlreg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'b0011010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [AW-1:0] wr_ptr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] ptr,
  output eng_state_t    state,
  output logic          start_det
);
  localparam int CW = $clog2(DW + 1);

  logic scl_q, sda_q;
  logic scl_rise, scl_fall, stop_det;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] shreg;
  logic in_ack, rb_flag;
  eng_state_t after_st;

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  assign wr_ptr    = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      state    <= ST_IDLE;
      after_st <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      in_ack   <= 1'b0;
      rb_flag  <= 1'b0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      wr_en <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        in_ack  <= 1'b0;
        sda_oe  <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_PTR, ST_WDAT: begin
            if (scl_rise && !in_ack && bit_cnt != CW'(DW)) begin
              shreg   <= {shreg[DW-2:0], sda_f};
              bit_cnt <= bit_cnt + 1'b1;
            end
            if (scl_fall) begin
              if (in_ack) begin
                // acknowledge bit over: move on
                in_ack  <= 1'b0;
                bit_cnt <= '0;
                state   <= after_st;
                if (after_st == ST_RDAT) begin
                  shreg  <= rd_data;
                  sda_oe <= ~rd_data[DW-1];
                end else begin
                  sda_oe <= 1'b0;
                end
              end else if (bit_cnt == CW'(DW)) begin
                unique case (state)
                  ST_ADDR: begin
                    if (shreg[DW-1:1] == SLV_ADDR) begin
                      sda_oe   <= 1'b1;
                      in_ack   <= 1'b1;
                      after_st <= shreg[0] ? ST_RDAT : ST_PTR;
                    end else begin
                      state <= ST_IDLE;
                    end
                  end
                  ST_PTR: begin
                    sda_oe   <= 1'b1;
                    in_ack   <= 1'b1;
                    ptr      <= shreg[AW-1:0];
                    rb_flag  <= shreg[AW];
                    after_st <= ST_WDAT;
                  end
                  default: begin
                    sda_oe   <= 1'b1;
                    in_ack   <= 1'b1;
                    wr_en    <= 1'b1;
                    wr_data  <= shreg;
                    after_st <= rb_flag ? ST_RDAT : ST_IDLE;
                  end
                endcase
              end
            end
          end
          ST_RDAT: begin
            if (scl_rise) begin
              if (in_ack) begin
                in_ack <= 1'b0;
                state  <= ST_IDLE;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
            if (scl_fall && !in_ack) begin
              if (bit_cnt == CW'(DW)) begin
                sda_oe <= 1'b0;
                in_ack <= 1'b1;
              end else begin
                shreg  <= {shreg[DW-2:0], 1'b0};
                sda_oe <= ~shreg[DW-2];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl_regfile.sv
`timescale 1ns/1ps
module ctl_regfile
  import ctlreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_ptr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_ptr,
  input  logic [DW-1:0]    status_i,
  output logic [DW-1:0]    rd_data,
  output logic [NW*DW-1:0] ctl_o
);
  logic [NW*DW-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= rst_image();
    else if (wr_en && wr_ptr != AW'(RO_IDX))
      q[wr_ptr*DW +: DW] <= wr_data;
  end

  always_comb begin
    if (rd_ptr == AW'(RO_IDX)) rd_data = status_i;
    else                       rd_data = q[rd_ptr*DW +: DW];
  end

  assign ctl_o = q;
endmodule

// File: rtl/ctlreg_i2c_slave.sv
`timescale 1ns/1ps
module ctlreg_i2c_slave
  import ctlreg_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'b0011010,
  parameter int         FILT_LEN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [DW-1:0]    status_i,
  output logic [NW*DW-1:0] ctl_o
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw, filt;
  logic scl_filt, sda_filt;
  logic wr_en, start_det;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] wr_data, rd_data;
  eng_state_t eng_state;

  assign raw = {sda_i, scl_i};

  generate
    for (genvar g = 0; g < NLINE; g++) begin : g_line
      i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .line_i(raw[g]), .line_o(filt[g])
      );
    end
  endgenerate

  assign scl_filt = filt[0];
  assign sda_filt = filt[1];

  i2c_byte_engine #(.SLV_ADDR(SLV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_filt), .sda_f(sda_filt),
    .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .wr_ptr(wr_ptr),
    .wr_data(wr_data), .ptr(rd_ptr), .state(eng_state), .start_det(start_det)
  );

  ctl_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr),
    .wr_data(wr_data), .rd_ptr(rd_ptr), .status_i(status_i),
    .rd_data(rd_data), .ctl_o(ctl_o)
  );
endmodule

// File: rtl/ctlreg_i2c_checker.sv
`timescale 1ns/1ps
module ctlreg_i2c_checker
  import ctlreg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_f,
  input logic             sda_oe,
  input eng_state_t       state,
  input logic             start_det,
  input logic             wr_en,
  input logic [AW-1:0]    wr_ptr,
  input logic [DW-1:0]    wr_data,
  input logic [NW*DW-1:0] ctl_o
);
  logic [AW-1:0] last_ptr;
  logic [DW-1:0] last_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ptr  <= '0;
      last_data <= '0;
    end else begin
      last_ptr  <= wr_ptr;
      last_data <= wr_data;
    end
  end

  a_r10_drive_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f);

  a_r2_idle_releases_sda: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  a_r9_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == ST_ADDR && !sda_oe));

  a_r7_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ptr == AW'(RO_IDX)) |=> $stable(ctl_o));

  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_ptr != AW'(RO_IDX)) |=> (ctl_o[last_ptr*DW +: DW] == last_data));
endmodule

bind ctlreg_i2c_slave ctlreg_i2c_checker chk_i (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_filt), .sda_oe(sda_oe),
  .state(eng_state), .start_det(start_det), .wr_en(wr_en),
  .wr_ptr(wr_ptr), .wr_data(wr_data), .ctl_o(ctl_o)
);

// File: tb/ctlreg_i2c_slave_tb_top.sv
`timescale 1ns/1ps
module ctlreg_i2c_slave_tb_top;
  localparam int CLK_PERIOD = 488;
  localparam int H = 20;
  localparam int Q = 10;
  localparam logic [7:0] STATUS = 8'h9C;
  localparam logic [55:0] RST_IMG = 56'h00000000330000;
  localparam int NV = 14;
  // {op, pointer byte, write data, expected read}; op 0 write+read, 1 readback, 2 read
  localparam logic [25:0] VEC [NV] = '{
    {2'd2, 8'h02, 8'h00, 8'h33},  // R1 reset value through the bus
    {2'd2, 8'h00, 8'h00, 8'h00},  // R1
    {2'd0, 8'h01, 8'hA5, 8'hA5},
    {2'd0, 8'h06, 8'h5A, 8'h5A},
    {2'd1, 8'h03, 8'hC3, 8'hC3},
    {2'd0, 8'h02, 8'h77, 8'h77},
    {2'd1, 8'h04, 8'hFF, 8'hFF},
    {2'd0, 8'hF5, 8'h66, 8'h66},  // R4 high bits ignored, register 5
    {2'd2, 8'h01, 8'h00, 8'hA5},
    {2'd0, 8'h07, 8'h12, 8'h9C},  // R7 write ignored, status returned
    {2'd1, 8'h07, 8'h34, 8'h9C},  // R7 readback of status
    {2'd0, 8'h00, 8'h20, 8'h20},  // R8 power-down bit stored
    {2'd2, 8'h02, 8'h00, 8'h77},  // R8 no clearing by that bit
    {2'd2, 8'h05, 8'h00, 8'h66}
  };

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_line, sda_oe;
  logic [55:0] ctl_o;
  int checks = 0, fails = 0;
  bit done = 0;

  assign sda_line = m_sda & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctlreg_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .status_i(STATUS), .ctl_o(ctl_o)
  );

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic i2c_start;
    m_scl = 0; wclk(Q); m_sda = 1; wclk(Q); m_scl = 1; wclk(H); m_sda = 0; wclk(H);
  endtask

  task automatic i2c_stop;
    m_scl = 0; wclk(Q); m_sda = 0; wclk(Q); m_scl = 1; wclk(H); m_sda = 1; wclk(H);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, inout int nacks);
    for (int i = 7; i >= 0; i--) begin
      m_scl = 0; wclk(Q); m_sda = b[i];
      if (glitch && i == 3) begin m_scl = 1; wclk(1); m_scl = 0; end
      wclk(Q); m_scl = 1; wclk(H);
    end
    m_scl = 0; wclk(Q); m_sda = 1; wclk(Q); m_scl = 1; wclk(Q);
    if (sda_line) nacks++;
    wclk(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_scl = 0; wclk(Q); m_sda = 1; wclk(Q); m_scl = 1; wclk(Q);
      b[i] = sda_line; wclk(Q);
    end
    m_scl = 0; wclk(Q); m_sda = 1; wclk(Q); m_scl = 1; wclk(H);
  endtask

  initial begin
    logic [7:0] rd;
    int nk;
    rst_n = 0; wclk(3); rst_n = 1; wclk(4);
    check("R1 reset image on ctl_o", {8'h0, ctl_o}, {8'h0, RST_IMG});

    for (int v = 0; v < NV; v++) begin
      logic [1:0] op; logic [7:0] pb, wd, ex; int p;
      {op, pb, wd, ex} = VEC[v];
      p = int'(pb[2:0]);
      nk = 0;
      rd = 8'h00;
      if (op == 2'd1) begin
        i2c_start; send_byte(8'h34, 0, nk); send_byte(pb | 8'h08, 0, nk);
        send_byte(wd, 0, nk); recv_byte(rd); i2c_stop;
        check($sformatf("R6 readback vec %0d", v), {56'h0, rd}, {56'h0, ex});
      end else begin
        if (op == 2'd0) begin
          i2c_start; send_byte(8'h34, 0, nk); send_byte(pb, 0, nk);
          send_byte(wd, 0, nk); i2c_stop;
          if (p != 7)
            check($sformatf("R3 ctl_o slice vec %0d", v), {56'h0, ctl_o[p*8 +: 8]}, {56'h0, ex});
        end
        i2c_start; send_byte(8'h34, 0, nk); send_byte(pb, 0, nk);
        i2c_start; send_byte(8'h35, 0, nk); recv_byte(rd); i2c_stop;
        check($sformatf("R5 read vec %0d", v), {56'h0, rd}, {56'h0, ex});
      end
      check($sformatf("R2 acks vec %0d", v), nk, 0);
    end

    // R7: ctl_o untouched by the writes to register 7 above
    check("R7 ctl_o after ro writes", {8'h0, ctl_o}, {8'h0, 56'h66_FF_C3_77_A5_20} | 56'h5A_000000000000);

    // R2: wrong address is never acknowledged, nothing changes
    nk = 0;
    i2c_start; send_byte(8'h36, 0, nk); send_byte(8'h01, 0, nk); send_byte(8'hEE, 0, nk); i2c_stop;
    check("R2 foreign address nacks", nk, 3);
    check("R2 foreign address no write", {56'h0, ctl_o[15:8]}, {56'h0, 8'hA5});

    // R9: start in the middle of a pointer byte restarts reception
    nk = 0;
    i2c_start; send_byte(8'h34, 0, nk);
    for (int i = 0; i < 3; i++) begin
      m_scl = 0; wclk(Q); m_sda = 1; wclk(Q); m_scl = 1; wclk(H);
    end
    i2c_start; send_byte(8'h34, 0, nk); send_byte(8'h01, 0, nk); send_byte(8'h3C, 0, nk); i2c_stop;
    check("R9 acks after restart", nk, 0);
    check("R9 write after restart", {56'h0, ctl_o[15:8]}, {56'h0, 8'h3C});

    // R10: one-clock SCL pulse inside the data byte adds no bit
    nk = 0;
    i2c_start; send_byte(8'h34, 0, nk); send_byte(8'h06, 0, nk); send_byte(8'h96, 1, nk); i2c_stop;
    check("R10 glitch acks", nk, 0);
    check("R10 glitch filtered", {56'h0, ctl_o[55:48]}, {56'h0, 8'h96});

    // R8: reset pulse of one clock (over 200 ns) restores the reset image
    rst_n = 0; wclk(1); rst_n = 1; wclk(2);
    check("R8 reset pin clears registers", {8'h0, ctl_o}, {8'h0, RST_IMG});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R9 actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule